// File: doc/BRIEF.md
# Eight-Line Priority Encoder with Chain Flags

This block takes eight request lines and reports, as a 3-bit code, the number of the highest-numbered line that is requesting. Requests, the enable and all outputs are active low. The block is purely combinational, so its outputs follow its inputs with no clock.

Two status flags come with the code. The first, the group flag, is low when the encoder is enabled and some line is requesting. The second, the chain flag, is low when the encoder is enabled and no line is requesting. An idle encoder and an encoder whose line 0 won both show code 111, and these flags tell the two cases apart. The chain flag can drive the enable of a lower-priority encoder, so several encoders can form a wider priority scheme.

The line count is a parameter that must be a power of two. The default is 8. A second parameter selects between two ways of building the code stage.

Top module: `prio_enc_chain`

## Requirements
- R1: A request line is active when it is 0 and idle when it is 1; bit i of `req_n` is line i.
- R2: While enabled, the code names the highest-numbered active line; line 7 has top priority and line 0 the lowest.
- R3: The code is the bitwise inverse of the winning line number: line 7 gives 000, line 4 gives 011, line 0 gives 111.
- R4: When `en_n` is 1, `code_n`, `grp_n` and `chain_n` are all 1, whatever the request lines hold.
- R5: `grp_n` is 0 exactly when `en_n` is 0 and at least one line is active.
- R6: `chain_n` is 0 exactly when `en_n` is 0 and no line is active.
- R7: While `en_n` is 0, `grp_n` and `chain_n` never hold the same level.
- R8: While enabled with every line idle, the outputs read code 111, `grp_n` = 1 and `chain_n` = 0.
- R9: While a higher-numbered line is active, the state of lower-numbered lines has no effect on the code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_n | input | 8 | Request lines, active low, bit index = line number |
| en_n | input | 1 | Enable, active low |
| code_n | output | 3 | Winning line number, inverted |
| grp_n | output | 1 | Low when enabled and some line is requesting |
| chain_n | output | 1 | Low when enabled and no line is requesting; feeds the enable of the next encoder |

## Verification
Every result is due in the cycle its stimulus is applied, because the block has no registers. The bench drives the inputs on the falling clock edge. It samples the outputs one nanosecond after the following rising edge, so the combinational paths have half a period to settle and no check races the drive. The 512 combinations of the request lines and the enable are compared against a priority search written in the bench. A table of vectors then fixes exact code values, the idle case and masking by higher lines.

// File: rtl/prio_enc_pkg.sv
package prio_enc_pkg;
   // width of a line number for a given line count
   function automatic int unsigned idx_width(input int unsigned lines);
      return (lines <= 2) ? 1 : $clog2(lines);
   endfunction

   // true when n is a power of two and at least two
   function automatic bit pow2_ok(input int unsigned n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction

   typedef enum int unsigned {
      ENC_OR_MASK = 0,
      ENC_SCAN    = 1
   } enc_style_e;
endpackage

// File: rtl/prio_enc_input.sv
module prio_enc_input #(
   parameter int unsigned LINES = 8
) (
   input  logic [LINES-1:0] req_n,
   input  logic             en_n,
   output logic [LINES-1:0] req_act,
   output logic             enabled,
   output logic             any_act
);
   assign enabled = ~en_n;
   assign req_act = ~req_n & {LINES{enabled}};
   assign any_act = |req_act;
endmodule

// File: rtl/prio_enc_mask.sv
module prio_enc_mask #(
   parameter int unsigned LINES = 8
) (
   input  logic [LINES-1:0] req_act,
   output logic [LINES-1:0] winner
);
   logic [LINES-1:0] higher;

   assign higher[LINES-1] = 1'b0;
   for (genvar i = 0; i < LINES - 1; i++) begin : g_chain
      assign higher[i] = higher[i+1] | req_act[i+1];
   end

   for (genvar i = 0; i < LINES; i++) begin : g_win
      assign winner[i] = req_act[i] & ~higher[i];
   end
endmodule

// File: rtl/prio_enc_index.sv
module prio_enc_index #(
   parameter int unsigned LINES = 8,
   parameter int unsigned STYLE = 0,
   localparam int unsigned IW   = prio_enc_pkg::idx_width(LINES)
) (
   input  logic [LINES-1:0] winner,
   output logic [IW-1:0]    index
);
   if (STYLE == prio_enc_pkg::ENC_OR_MASK) begin : g_or
      for (genvar b = 0; b < IW; b++) begin : g_bit
         logic [LINES-1:0] sel;
         for (genvar i = 0; i < LINES; i++) begin : g_sel
            assign sel[i] = winner[i] & (((i >> b) & 1) == 1);
         end
         assign index[b] = |sel;
      end
   end else begin : g_scan
      always_comb begin
         index = '0;
         for (int i = 0; i < LINES; i++) begin
            if (winner[i]) index = IW'(i);
         end
      end
   end
endmodule

// File: rtl/prio_enc_chain.sv
module prio_enc_chain #(
   parameter int unsigned LINES = 8,
   parameter int unsigned STYLE = 0,
   localparam int unsigned IW   = prio_enc_pkg::idx_width(LINES)
) (
   input  logic [LINES-1:0] req_n,
   input  logic             en_n,
   output logic [IW-1:0]    code_n,
   output logic             grp_n,
   output logic             chain_n
);
   initial begin
      assert (prio_enc_pkg::pow2_ok(LINES))
         else $error("LINES must be a power of two, at least 2");
      assert (STYLE <= 1)
         else $error("STYLE must be 0 or 1");
   end

   logic [LINES-1:0] req_act;
   logic [LINES-1:0] winner;
   logic             enabled;
   logic             any_act;
   logic [IW-1:0]    index;

   prio_enc_input #(.LINES(LINES)) u_in (
      .req_n   (req_n),
      .en_n    (en_n),
      .req_act (req_act),
      .enabled (enabled),
      .any_act (any_act)
   );

   prio_enc_mask #(.LINES(LINES)) u_mask (
      .req_act (req_act),
      .winner  (winner)
   );

   prio_enc_index #(.LINES(LINES), .STYLE(STYLE)) u_idx (
      .winner (winner),
      .index  (index)
   );

   assign code_n  = ~index;
   assign grp_n   = ~(enabled & any_act);
   assign chain_n = ~(enabled & ~any_act);
endmodule

// File: rtl/prio_enc_chain_chk.sv
module prio_enc_chain_chk #(
   parameter int unsigned LINES = 8,
   localparam int unsigned IW   = prio_enc_pkg::idx_width(LINES)
) (
   input logic [LINES-1:0] req_n,
   input logic             en_n,
   input logic [IW-1:0]    code_n,
   input logic             grp_n,
   input logic             chain_n
);
   always_comb begin
      // R4: disabled encoder shows all ones
      p_off_all_high_r4: assert (en_n !== 1'b1 ||
                                 (code_n == '1 && grp_n && chain_n));
      // R7: flags differ while enabled
      p_flags_differ_r7: assert (en_n !== 1'b0 || (grp_n != chain_n));
      // R5: group flag follows the presence of a request
      p_grp_any_r5: assert (en_n !== 1'b0 || (grp_n == &req_n));
      // R8: idle enabled encoder reads code all ones
      p_idle_code_r8: assert (en_n !== 1'b0 || req_n != '1 || code_n == '1);
      // R2: the line named by the code is active
      p_winner_active_r2: assert (en_n !== 1'b0 || req_n == '1 ||
                                  req_n[~code_n] == 1'b0);
   end
endmodule

bind prio_enc_chain prio_enc_chain_chk #(.LINES(LINES)) u_chk (
   .req_n   (req_n),
   .en_n    (en_n),
   .code_n  (code_n),
   .grp_n   (grp_n),
   .chain_n (chain_n)
);

// File: tb/prio_enc_chain_tb_top.sv
module prio_enc_chain_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] req_n = 8'hFF;
   logic       en_n = 1'b1;
   logic [2:0] code_n;
   logic       grp_n;
   logic       chain_n;
   int         n_vec = 0;
   int         n_bad = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   prio_enc_chain dut_i (
      .req_n   (req_n),
      .en_n    (en_n),
      .code_n  (code_n),
      .grp_n   (grp_n),
      .chain_n (chain_n)
   );

   // {en_n, req_n, code_n, grp_n, chain_n}
   localparam int NV = 16;
   localparam logic [13:0] VEC [NV] = '{
      {1'b0, 8'hFF, 3'b111, 1'b1, 1'b0},  // R8 idle
      {1'b0, 8'h7F, 3'b000, 1'b0, 1'b1},  // R3 line 7
      {1'b0, 8'hFE, 3'b111, 1'b0, 1'b1},  // R3 line 0
      {1'b0, 8'h00, 3'b000, 1'b0, 1'b1},  // R2 all active
      {1'b0, 8'hFD, 3'b110, 1'b0, 1'b1},
      {1'b0, 8'hFB, 3'b101, 1'b0, 1'b1},
      {1'b0, 8'hF7, 3'b100, 1'b0, 1'b1},
      {1'b0, 8'hEF, 3'b011, 1'b0, 1'b1},
      {1'b0, 8'hDF, 3'b010, 1'b0, 1'b1},
      {1'b0, 8'hBF, 3'b001, 1'b0, 1'b1},
      {1'b0, 8'hFC, 3'b110, 1'b0, 1'b1},  // R9 line 1 masks 0
      {1'b0, 8'hAA, 3'b001, 1'b0, 1'b1},  // R9 line 6 masks 4,2,0
      {1'b0, 8'h55, 3'b000, 1'b0, 1'b1},  // R9 line 7 wins
      {1'b1, 8'h00, 3'b111, 1'b1, 1'b1},  // R4 off, all requesting
      {1'b1, 8'hFF, 3'b111, 1'b1, 1'b1},  // R4 off, idle
      {1'b0, 8'hE0, 3'b011, 1'b0, 1'b1}   // R9 line 4 masks 3..0
   };

   task automatic check(input string req, input logic [4:0] exp);
      logic [4:0] got;
      got = {code_n, grp_n, chain_n};
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s en_n=%b req_n=%h got code/grp/chain=%b expected %b",
                  req, en_n, req_n, got, exp);
      end
   endtask

   task automatic apply(input logic e, input logic [7:0] r);
      @(negedge clk);
      en_n  = e;
      req_n = r;
      @(posedge clk);
      #1;
   endtask

   function automatic logic [4:0] model(input logic e, input logic [7:0] r);
      logic [2:0] c;
      bit hit;
      c = 3'b111;
      hit = 1'b0;
      if (e) return 5'b11111;
      for (int i = 7; i >= 0; i--) begin
         if (!hit && r[i] == 1'b0) begin
            c = ~3'(i);
            hit = 1'b1;
         end
      end
      return {c, ~hit, hit};
   endfunction

   initial begin
      #200000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;
      #1;
      check("R4 start state", 5'b11111);

      for (int k = 0; k < NV; k++) begin
         apply(VEC[k][13], VEC[k][12:5]);
         check("R2 R3 R4 R8 R9 table", VEC[k][4:0]);
      end

      for (int e = 0; e < 2; e++) begin
         for (int r = 0; r < 256; r++) begin
            apply(e[0], r[7:0]);
            check(e == 0 ? "R1 R2 R5 R6 R7 sweep" : "R4 sweep",
                  model(e[0], r[7:0]));
         end
      end

      // R6 toggling enable with idle lines
      apply(1'b0, 8'hFF);
      check("R6 idle enabled", 5'b11110);
      apply(1'b1, 8'hFF);
      check("R6 idle disabled", 5'b11111);
      // R5 single low line on a disabled encoder stays silent
      apply(1'b1, 8'h7F);
      check("R5 disabled request", 5'b11111);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule